// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM Core

This block models a synchronous SRAM with a registered read pipeline and a four-word burst counter. On every rising clock edge it looks at two active-low address strobes, one for a processor and one for a memory controller. When either is low, a new access begins and the address bus is captured as the burst base. After that edge, the active-low advance input steps the burst through the four words that share the base's upper address bits. The burst can run in linear or interleaved order, and it can be held on its current word for as long as advance stays high.

Writes can be whole-word, through a global write strobe, or per byte lane, through a byte-write strobe with a lane mask. An access started by the controller strobe decides read or write on its first edge. An access started by the processor strobe always reads on its first edge and can only write from the next edge onward. Three chip-select lines are checked when an access starts. Read data comes out of an output register, and a drive flag stands in for the tri-state control of a shared data bus. A deselect turns that flag off after a single cycle.

Top module: `sbsram_core`

## Requirements
- R1: A rising edge with `proc_stb_n` or `ctl_stb_n` low starts a new access with `addr` as the burst base. The word accessed on that edge is the base word, even if `adv_n` is low.
- R2: On an access started by `ctl_stb_n` alone, the write controls are sampled on the start edge. A write on that edge stores `wdata` at the base address.
- R3: On an access started by `proc_stb_n` low, the write controls are ignored on the start edge, which is always a read of the base. On the following edge, active write controls write the burst word addressed on that edge. When both strobes are low together, the processor rule applies.
- R4: On an edge with no strobe inside an active access, `adv_n` low moves to the next beat. Address bits above bit 1 always equal the base. With `burst_ilv` = 0 (linear order), the low two bits of beat k are (base + k) mod 4.
- R5: With `burst_ilv` = 1 (interleaved order), the low two bits of beat k are the base's low two bits XOR k.
- R6: On an edge with no strobe, `adv_n` high keeps the beat. That edge reads or writes the same word again.
- R7: `wr_all_n` low writes every byte lane. Otherwise, `wr_byte_n` low writes only lane i where `byte_sel_n[i]` is low, lane i being `wdata[i*BYTE_W +: BYTE_W]`. With both strobes high, the edge is a read.
- R8: An access is selected only when `chip_en_n` = 0, `chip_sel_hi` = 1 and `chip_sel_lo_n` = 0 on its start edge. A start edge with any other combination ends the current access and writes or reads nothing.
- R9: A word read on edge t is on `rd_data` after edge t+1. Write edges leave `rd_data` unchanged.
- R10: `rd_drive` is high only while `oe_n` is low and the output stage is live. The stage becomes live one edge after a selected start. A deselecting start on edge t turns `rd_drive` off after edge t+1. Data read on edge t-1 is still driven between edges t and t+1.
- R11: During reset, `rd_data` is 0 and `rd_drive` is 0. With no active access, non-strobe edges neither write nor read, whatever the advance and write inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Word address, captured on a start edge |
| proc_stb_n | input | 1 | Processor address strobe, active low |
| ctl_stb_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low; high holds the beat |
| wr_all_n | input | 1 | Whole-word write strobe, active low |
| wr_byte_n | input | 1 | Byte-lane write strobe, active low |
| byte_sel_n | input | DATA_W/BYTE_W | Per-lane write mask, active low |
| chip_en_n | input | 1 | Chip enable, active low |
| chip_sel_hi | input | 1 | Chip select, active high |
| chip_sel_lo_n | input | 1 | Chip select, active low |
| burst_ilv | input | 1 | Burst order: 0 linear, 1 interleaved |
| oe_n | input | 1 | Output enable, active low |
| wdata | input | DATA_W | Write data |
| rd_data | output | DATA_W | Registered read data |
| rd_drive | output | 1 | High when the data bus would be driven |

## Verification
The bench fills a small array and then runs bursts from every base offset in both orders. A counter that carried into bit 2, or that confused the XOR sequence with the add sequence, would return a word from the neighbouring group. Advance patterns that mix holds and steps catch a counter that keeps stepping on a hold, or that loses the held word. A processor-strobe start with the write strobe low checks that the first edge reads and that the write lands one edge later; a design that honoured the strobe early would corrupt the base word. All eight chip-select codes and a deselect right after a read check two things: that unselected starts neither write nor drive, and that the bus is released exactly one cycle late, not zero and not two.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

  // Low address bits for beat 'beat' of a burst based at 'base'.
  function automatic logic [1:0] beat_offset(input logic [1:0] base,
                                             input logic [1:0] beat,
                                             input logic       ilv);
    logic [1:0] lin;
    lin = base + beat;
    return ilv ? (base ^ beat) : lin;
  endfunction

endpackage

// File: rtl/sbsram_ctrl.sv
module sbsram_ctrl
  import sbsram_pkg::*;
#(
  parameter int NBYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              proc_stb_n,
  input  logic              ctl_stb_n,
  input  logic              adv_n,
  input  logic              wr_all_n,
  input  logic              wr_byte_n,
  input  logic [NBYTES-1:0] byte_sel_n,
  input  logic              chip_en_n,
  input  logic              chip_sel_hi,
  input  logic              chip_sel_lo_n,
  output logic              strobe,
  output logic              step,
  output op_e               op,
  output logic [NBYTES-1:0] byte_we,
  output logic              burst_on,
  output logic              live
);

  logic              selected;
  logic              wr_req;
  logic              active_q;
  logic              active_d;
  logic              live_q;
  logic [NBYTES-1:0] lane_mask;

  assign selected = ~chip_en_n & chip_sel_hi & ~chip_sel_lo_n;
  assign strobe   = ~proc_stb_n | ~ctl_stb_n;
  assign wr_req   = ~wr_all_n | ~wr_byte_n;

  always_comb begin
    if (!wr_all_n) begin
      lane_mask = '1;
    end else if (!wr_byte_n) begin
      lane_mask = ~byte_sel_n;
    end else begin
      lane_mask = '0;
    end
  end

  // Next-state decode: start edges, continuation edges, idle edges.
  always_comb begin
    active_d = active_q;
    op       = OP_NONE;
    step     = 1'b0;
    if (strobe) begin
      active_d = selected;
      if (selected) begin
        op = (!proc_stb_n || !wr_req) ? OP_READ : OP_WRITE;
      end
    end else if (active_q) begin
      step = ~adv_n;
      op   = wr_req ? OP_WRITE : OP_READ;
    end
  end

  assign byte_we = (op == OP_WRITE) ? lane_mask : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      live_q   <= 1'b0;
    end else begin
      active_q <= active_d;
      live_q   <= active_q;
    end
  end

  assign burst_on = active_q;
  assign live     = live_q;

endmodule

// File: rtl/sbsram_burst.sv
module sbsram_burst
  import sbsram_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              step,
  input  logic              ilv,
  input  logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] op_addr,
  output logic [ADDR_W-1:0] base_q,
  output logic [1:0]        beat_q
);

  logic              load;
  logic [1:0]        beat_d;
  logic [ADDR_W-1:0] base_d;
  logic [ADDR_W-1:0] src;

  always_comb begin
    load   = start | step;
    beat_d = beat_q;
    base_d = base_q;
    if (start) begin
      beat_d = 2'd0;
      base_d = addr;
    end else if (step) begin
      beat_d = beat_q + 2'd1;
    end
  end

  // The word touched on this edge: the new base on a start, else the
  // held base with the low bits ordered by the selected burst mode.
  assign src     = start ? addr : base_q;
  assign op_addr = {src[ADDR_W-1:2], beat_offset(src[1:0], beat_d, ilv)};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_q <= 2'd0;
      base_q <= '0;
    end else if (load) begin
      beat_q <= beat_d;
      base_q <= base_d;
    end
  end

endmodule

// File: rtl/sbsram_array.sv
module sbsram_array
  import sbsram_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int NBYTES = 4,
  parameter int BYTE_W = 9
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  op_e                      op,
  input  logic [ADDR_W-1:0]        op_addr,
  input  logic [NBYTES-1:0]        byte_we,
  input  logic [NBYTES*BYTE_W-1:0] wdata,
  output logic [NBYTES*BYTE_W-1:0] rd_data
);

  localparam int DEPTH = 1 << ADDR_W;

  logic              rd_pend_q;
  logic [ADDR_W-1:0] rd_addr_q;
  logic              rd_issue;

  assign rd_issue = (op == OP_READ);

  // Address register stage of the read pipeline.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_pend_q <= 1'b0;
      rd_addr_q <= '0;
    end else begin
      rd_pend_q <= rd_issue;
      if (rd_issue) begin
        rd_addr_q <= op_addr;
      end
    end
  end

  // One storage array and one output register per byte lane.
  for (genvar g = 0; g < NBYTES; g++) begin : g_lane
    logic [BYTE_W-1:0] cells [DEPTH];
    logic [BYTE_W-1:0] dout_q;

    always_ff @(posedge clk) begin
      if (byte_we[g]) begin
        cells[op_addr] <= wdata[g*BYTE_W +: BYTE_W];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dout_q <= '0;
      end else if (rd_pend_q) begin
        dout_q <= cells[rd_addr_q];
      end
    end

    assign rd_data[g*BYTE_W +: BYTE_W] = dout_q;
  end

endmodule

// File: rtl/sbsram_core.sv
module sbsram_core
  import sbsram_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 36,
  parameter int BYTE_W = 9
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [ADDR_W-1:0]          addr,
  input  logic                       proc_stb_n,
  input  logic                       ctl_stb_n,
  input  logic                       adv_n,
  input  logic                       wr_all_n,
  input  logic                       wr_byte_n,
  input  logic [DATA_W/BYTE_W-1:0]   byte_sel_n,
  input  logic                       chip_en_n,
  input  logic                       chip_sel_hi,
  input  logic                       chip_sel_lo_n,
  input  logic                       burst_ilv,
  input  logic                       oe_n,
  input  logic [DATA_W-1:0]          wdata,
  output logic [DATA_W-1:0]          rd_data,
  output logic                       rd_drive
);

  localparam int NBYTES = DATA_W / BYTE_W;

  logic              strobe;
  logic              step;
  logic              burst_on;
  logic              live;
  op_e               op;
  logic [NBYTES-1:0] byte_we;
  logic [ADDR_W-1:0] op_addr;
  logic [ADDR_W-1:0] base_q;
  logic [1:0]        beat_q;

  sbsram_ctrl #(
    .NBYTES(NBYTES)
  ) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .proc_stb_n   (proc_stb_n),
    .ctl_stb_n    (ctl_stb_n),
    .adv_n        (adv_n),
    .wr_all_n     (wr_all_n),
    .wr_byte_n    (wr_byte_n),
    .byte_sel_n   (byte_sel_n),
    .chip_en_n    (chip_en_n),
    .chip_sel_hi  (chip_sel_hi),
    .chip_sel_lo_n(chip_sel_lo_n),
    .strobe       (strobe),
    .step         (step),
    .op           (op),
    .byte_we      (byte_we),
    .burst_on     (burst_on),
    .live         (live)
  );

  sbsram_burst #(
    .ADDR_W(ADDR_W)
  ) u_burst (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (strobe),
    .step   (step),
    .ilv    (burst_ilv),
    .addr   (addr),
    .op_addr(op_addr),
    .base_q (base_q),
    .beat_q (beat_q)
  );

  sbsram_array #(
    .ADDR_W(ADDR_W),
    .NBYTES(NBYTES),
    .BYTE_W(BYTE_W)
  ) u_array (
    .clk    (clk),
    .rst_n  (rst_n),
    .op     (op),
    .op_addr(op_addr),
    .byte_we(byte_we),
    .wdata  (wdata),
    .rd_data(rd_data)
  );

  assign rd_drive = live & ~oe_n;

endmodule

// File: rtl/sbsram_chk.sv
module sbsram_chk #(
  parameter int ADDR_W = 9,
  parameter int NBYTES = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              proc_stb_n,
  input logic              ctl_stb_n,
  input logic              adv_n,
  input logic              chip_en_n,
  input logic              chip_sel_hi,
  input logic              chip_sel_lo_n,
  input logic              oe_n,
  input logic              rd_drive,
  input logic [NBYTES-1:0] byte_we,
  input logic [ADDR_W-1:0] op_addr,
  input logic [ADDR_W-1:0] base_q,
  input logic [1:0]        beat_q,
  input logic              burst_on
);

  logic any_stb;
  logic sel_in;

  assign any_stb = ~proc_stb_n | ~ctl_stb_n;
  assign sel_in  = ~chip_en_n & chip_sel_hi & ~chip_sel_lo_n;

  p_base_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
    any_stb |=> (base_q == $past(addr)));

  p_proc_start_no_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !proc_stb_n |-> (byte_we == '0));

  p_upper_bits_fixed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_on && !any_stb) |-> (op_addr[ADDR_W-1:2] == base_q[ADDR_W-1:2]));

  p_hold_beat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_on && !any_stb && adv_n) |=> $stable(beat_q));

  p_deselect_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (any_stb && !sel_in) |-> (byte_we == '0));

  p_drive_needs_oe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_drive |-> !oe_n);

  p_release_after_one_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (any_stb && !sel_in) |=> ##1 !rd_drive);

  p_idle_no_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!burst_on && !any_stb) |-> (byte_we == '0));

endmodule

bind sbsram_core sbsram_chk #(
  .ADDR_W(ADDR_W),
  .NBYTES(NBYTES)
) u_sbsram_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .addr         (addr),
  .proc_stb_n   (proc_stb_n),
  .ctl_stb_n    (ctl_stb_n),
  .adv_n        (adv_n),
  .chip_en_n    (chip_en_n),
  .chip_sel_hi  (chip_sel_hi),
  .chip_sel_lo_n(chip_sel_lo_n),
  .oe_n         (oe_n),
  .rd_drive     (rd_drive),
  .byte_we      (byte_we),
  .op_addr      (op_addr),
  .base_q       (base_q),
  .beat_q       (beat_q),
  .burst_on     (burst_on)
);

// File: tb/test_sbsram_core.sv
module test_sbsram_core;

  localparam int TCLK  = 10;
  localparam int AW    = 6;
  localparam int DW    = 18;
  localparam int BW    = 9;
  localparam int NB    = DW / BW;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] addr;
  logic          proc_stb_n, ctl_stb_n, adv_n, wr_all_n, wr_byte_n;
  logic [NB-1:0] byte_sel_n;
  logic          chip_en_n, chip_sel_hi, chip_sel_lo_n, burst_ilv, oe_n;
  logic [DW-1:0] wdata;
  logic [DW-1:0] rd_data;
  logic          rd_drive;

  always #(TCLK/2) clk = ~clk;

  sbsram_core #(.ADDR_W(AW), .DATA_W(DW), .BYTE_W(BW)) i_sbsram_core (
    .clk(clk), .rst_n(rst_n), .addr(addr), .proc_stb_n(proc_stb_n),
    .ctl_stb_n(ctl_stb_n), .adv_n(adv_n), .wr_all_n(wr_all_n),
    .wr_byte_n(wr_byte_n), .byte_sel_n(byte_sel_n), .chip_en_n(chip_en_n),
    .chip_sel_hi(chip_sel_hi), .chip_sel_lo_n(chip_sel_lo_n),
    .burst_ilv(burst_ilv), .oe_n(oe_n), .wdata(wdata),
    .rd_data(rd_data), .rd_drive(rd_drive)
  );

  int            n_chk = 0;
  int            n_err = 0;
  logic [DW-1:0] ref_mem [DEPTH];
  bit            prv_rd = 1'b0;
  logic [DW-1:0] prv_val = '0;
  string         prv_tag = "";

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] beat_addr(input logic [AW-1:0] b, input int k, input bit ilv);
    logic [1:0] lo;
    lo = ilv ? (b[1:0] ^ 2'(k)) : 2'(b[1:0] + 2'(k));
    return {b[AW-1:2], lo};
  endfunction

  task automatic rest();
    proc_stb_n = 1'b1; ctl_stb_n = 1'b1; adv_n = 1'b1;
    wr_all_n = 1'b1; wr_byte_n = 1'b1; byte_sel_n = '1;
    chip_en_n = 1'b0; chip_sel_hi = 1'b1; chip_sel_lo_n = 1'b0; oe_n = 1'b0;
  endtask

  // One clock: the edge samples the inputs; then the read issued on the
  // previous edge must be on rd_data.
  task automatic tick(input bit is_rd, input logic [DW-1:0] val, input string tag);
    @(posedge clk);
    @(negedge clk);
    if (prv_rd) chk(rd_data == prv_val, prv_tag, 32'(rd_data), 32'(prv_val));
    prv_rd = is_rd; prv_val = val; prv_tag = tag;
  endtask

  task automatic idle();
    rest();
    tick(1'b0, '0, "");
  endtask

  task automatic ctl_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    rest(); ctl_stb_n = 1'b0; wr_all_n = 1'b0; addr = a; wdata = d;
    ref_mem[a] = d;
    tick(1'b0, '0, "");
  endtask

  task automatic ctl_read(input logic [AW-1:0] a, input string tag);
    rest(); ctl_stb_n = 1'b0; addr = a;
    tick(1'b1, ref_mem[a], tag);
  endtask

  task automatic burst_rd(input logic [AW-1:0] b, input bit ilv);
    rest(); burst_ilv = ilv; ctl_stb_n = 1'b0; adv_n = 1'b0; addr = b;
    tick(1'b1, ref_mem[b], "R1");
    for (int k = 1; k < 4; k++) begin
      rest(); adv_n = 1'b0;
      tick(1'b1, ref_mem[beat_addr(b, k, ilv)], ilv ? "R5" : "R4");
    end
    idle();
  endtask

  initial begin
    #(TCLK * 100000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int advs [6] = '{0, 1, 1, 0, 1, 0};
    int bt;
    rst_n = 1'b0; rest(); burst_ilv = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    chk(rd_drive == 1'b0, "R11", 32'(rd_drive), 0);
    chk(rd_data == '0, "R11", 32'(rd_data), 0);
    rst_n = 1'b1;
    idle();

    // R2: single controller writes, then read back (R9)
    for (int a = 0; a < DEPTH; a++) ctl_write(AW'(a), DW'((a * 37) ^ 18'h2A5A5));
    idle();
    for (int a = 0; a < DEPTH; a++) ctl_read(AW'(a), "R2");
    idle();
    chk(rd_drive == 1'b1, "R10", 32'(rd_drive), 1);

    // R1/R4/R5: every base in both orders
    for (int m = 0; m < 2; m++)
      for (int b = 0; b < DEPTH; b++) burst_rd(AW'(b), m[0]);
    burst_ilv = 1'b0;

    // R6: advance holds
    rest(); ctl_stb_n = 1'b0; addr = 6'd13;
    tick(1'b1, ref_mem[13], "R6");
    bt = 0;
    for (int i = 0; i < 6; i++) begin
      rest(); adv_n = advs[i][0];
      if (advs[i] == 0) bt++;
      tick(1'b1, ref_mem[beat_addr(6'd13, bt, 1'b0)], "R6");
    end
    idle();

    // R3: processor start ignores write, writes on next edge
    rest(); proc_stb_n = 1'b0; addr = 6'd20; wr_all_n = 1'b0; wdata = 18'h3C3C3;
    tick(1'b1, ref_mem[20], "R3");
    rest(); wr_all_n = 1'b0; wdata = 18'h15A5A; ref_mem[20] = 18'h15A5A;
    tick(1'b0, '0, "");
    idle(); ctl_read(6'd20, "R3"); idle();
    rest(); proc_stb_n = 1'b0; addr = 6'd21; wr_all_n = 1'b0; wdata = 18'h00F0F;
    tick(1'b1, ref_mem[21], "R3");
    rest(); adv_n = 1'b0;
    tick(1'b1, ref_mem[22], "R3");
    idle(); ctl_read(6'd21, "R3"); idle();
    // both strobes low: processor rule applies
    rest(); proc_stb_n = 1'b0; ctl_stb_n = 1'b0; addr = 6'd23; wr_all_n = 1'b0; wdata = 18'h01111;
    tick(1'b1, ref_mem[23], "R3");
    idle(); ctl_read(6'd23, "R3"); idle();

    // R2/R5: interleaved burst write from base 42
    for (int k = 0; k < 4; k++) begin
      rest(); burst_ilv = 1'b1; wr_all_n = 1'b0;
      if (k == 0) begin ctl_stb_n = 1'b0; addr = 6'd42; end
      else adv_n = 1'b0;
      wdata = DW'(k * 4099 + 7);
      ref_mem[beat_addr(6'd42, k, 1'b1)] = wdata;
      tick(1'b0, '0, "");
    end
    idle();
    burst_rd(6'd42, 1'b1);
    for (int k = 0; k < 4; k++) ctl_read(beat_addr(6'd42, k, 1'b1), "R2");
    idle();
    burst_ilv = 1'b0;

    // R7: byte lanes
    rest(); ctl_stb_n = 1'b0; addr = 6'd5; wr_byte_n = 1'b0; byte_sel_n = 2'b10; wdata = 18'h1F0F0;
    ref_mem[5][8:0] = wdata[8:0];
    tick(1'b0, '0, "");
    rest(); wr_byte_n = 1'b0; byte_sel_n = 2'b01; wdata = 18'h0AAAA;
    ref_mem[5][17:9] = wdata[17:9];
    tick(1'b0, '0, "");
    rest(); byte_sel_n = 2'b00; wdata = '0;
    tick(1'b1, ref_mem[5], "R7");
    rest(); wr_byte_n = 1'b0; byte_sel_n = 2'b11; wdata = '0;
    tick(1'b0, '0, "");
    idle(); ctl_read(6'd5, "R7"); idle();

    // R8: every chip-select code
    for (int c = 0; c < 8; c++) begin
      rest(); {chip_en_n, chip_sel_hi, chip_sel_lo_n} = 3'(c);
      ctl_stb_n = 1'b0; wr_all_n = 1'b0; addr = 6'd50; wdata = DW'(c * 111 + 5);
      if (c == 2) ref_mem[50] = wdata;
      tick(1'b0, '0, "");
      idle();
      chk(rd_drive == (c == 2), "R8", 32'(rd_drive), 32'(c == 2));
      ctl_read(6'd50, "R8"); idle();
    end

    // R9/R10: single-cycle deselect after a read, then R11 quiet edges
    ctl_read(6'd30, "R9");
    rest(); chip_en_n = 1'b1; ctl_stb_n = 1'b0;
    tick(1'b0, '0, "");
    chk(rd_drive == 1'b1, "R10", 32'(rd_drive), 1);
    for (int i = 0; i < 3; i++) begin
      rest(); wr_all_n = 1'b0; adv_n = 1'b0; wdata = '0;
      tick(1'b0, '0, "");
      chk(rd_drive == 1'b0, "R10", 32'(rd_drive), 0);
    end
    for (int a = 28; a < 32; a++) ctl_read(AW'(a), "R11");
    idle();

    // R10: output enable
    ctl_read(6'd7, "R9"); idle();
    chk(rd_drive == 1'b1, "R10", 32'(rd_drive), 1);
    oe_n = 1'b1; #1;
    chk(rd_drive == 1'b0, "R10", 32'(rd_drive), 0);
    oe_n = 1'b0;

    // final sweep of the whole array
    for (int a = 0; a < DEPTH; a++) ctl_read(AW'(a), "R7");
    idle();

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule